// File: doc/BRIEF.md
# Programmable Parallel Port Controller

This block gives a processor three general-purpose parallel ports, called A, B and C, each as wide as the data bus (8 bits by default). The processor reaches the ports through a small register window. It selects a register with a 2-bit select, and it moves data with active-low chip-select, read and write strobes. All strobes are sampled in the block's single clock domain. Each port pin comes out as an input level, an output latch value and an output-enable bit, so the pad ring can build the tristate buffer.

A single control register accepts two kinds of word. The top bit of the word selects the kind. A word with the top bit set is a direction word: it sets Port A, Port B, the upper half of Port C and the lower half of Port C each to input or to output, and it clears every output latch. A word with the top bit clear changes one chosen Port C latch bit and leaves the other Port C bits and the stored direction word as they were. Output ports drive their latch. A read of an input port returns the live pin levels, which are never latched.

A bus-cycle state machine decides what each strobe pattern means. The states are ST_IDLE, ST_READ, ST_WRITE, ST_WR_HOLD and ST_CLASH. The transitions are:
- ST_IDLE goes to ST_READ on a selected read. It goes to ST_WRITE on a selected write, and it goes to ST_CLASH when read and write are both low under chip select.
- ST_READ stays in ST_READ while the read continues. It goes to ST_CLASH if write joins the read, and it goes back to ST_IDLE when the read ends.
- ST_WRITE always goes to ST_WR_HOLD. ST_WRITE is the single cycle in which the captured word is committed.
- ST_WR_HOLD stays in ST_WR_HOLD until the write strobe or chip select is released, and then goes to ST_IDLE.
- ST_CLASH stays in ST_CLASH until both strobes are high or chip select is high, and then goes to ST_IDLE.

Top module: `ppio_ctrl`

## Requirements
- R1: After reset, every output latch is zero, every output-enable bit is zero, and the control register reads 9Bh (all ports are inputs).
- R2: Register select 0 addresses Port A, 1 addresses Port B, 2 addresses Port C and 3 addresses the control register. A write to a port register appears on that port's output latch pins by the third rising clock edge after the write strobe is first sampled low. One strobe assertion commits exactly one write.
- R3: A read of a port half that is set as input returns the present pin levels. If the pins change while the read is held, the returned data follows them.
- R4: A read of a port that is set as output returns its output latch value.
- R5: In a direction word, bit 4 = 1 makes Port A an input, bit 3 = 1 makes upper Port C an input, bit 1 = 1 makes Port B an input and bit 0 = 1 makes lower Port C an input. The output-enable bits of each port or half are all ones when it is an output and all zeros when it is an input. Examples: 8Bh gives A out and B, C in; 89h gives A, B out and C in; 80h makes every port an output.
- R6: A control write with bit 7 = 1 clears all output latches to zero. A read of the control register returns the last direction word written.
- R7: A control write with bit 7 = 0 loads bit 0 into the Port C latch bit chosen by bits 3:1, leaves every other Port C bit unchanged, and does not alter the control register read-back. For example, 05h sets PC2, 0Dh sets PC6 and 0Ch clears PC6.
- R8: The two halves of Port C have independent directions. A Port C read merges the pin levels of an input half with the latch bits of an output half.
- R9: A bus cycle with read and write both low under chip select changes no register and does not drive the data bus.
- R10: While chip select is high, the read and write strobes have no effect.
- R11: The block drives the data bus (bus_oe = 1) only during a selected read. At all other times bus_oe is 0 and bus_dout is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| reg_sel | input | 2 | Register select: 0 A, 1 B, 2 C, 3 control |
| bus_din | input | 8 | Write data from the processor |
| bus_dout | output | 8 | Read data to the processor |
| bus_oe | output | 1 | High while the block drives read data |
| pa_in | input | 8 | Port A pin levels |
| pa_out | output | 8 | Port A output latch |
| pa_oe | output | 8 | Port A output enables |
| pb_in | input | 8 | Port B pin levels |
| pb_out | output | 8 | Port B output latch |
| pb_oe | output | 8 | Port B output enables |
| pc_in | input | 8 | Port C pin levels |
| pc_out | output | 8 | Port C output latch |
| pc_oe | output | 8 | Port C output enables |

## Verification
The hardest case to reach from the ports is a strobe conflict. Read and write must fall in the same cycle, or write must fall in the middle of a read that is already running. Random bus operations almost never produce either pattern, so the stimulus forces both edges on the same clock phase. It then holds the conflict for several cycles and reads every register back afterwards to show that nothing changed. The single-bit command is driven under random direction words and random bit indices, and each result is compared against a bench model that also applies the latch-clearing effect of every direction word. A read held open while the pins toggle shows that the input path is live and not latched.

// File: rtl/ppio_pkg.sv
package ppio_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_WRITE,
        ST_WR_HOLD,
        ST_CLASH
    } bus_state_e;

    typedef enum logic [1:0] {
        SEL_A    = 2'd0,
        SEL_B    = 2'd1,
        SEL_C    = 2'd2,
        SEL_CTRL = 2'd3
    } reg_sel_e;

    // Bit positions inside a direction word
    localparam int DIR_A_BIT  = 4;
    localparam int DIR_CU_BIT = 3;
    localparam int DIR_B_BIT  = 1;
    localparam int DIR_CL_BIT = 0;

    // Reset value of the control register: every port an input
    localparam logic [7:0] CTRL_RESET = 8'h9B;

    typedef struct packed {
        logic a_in;
        logic b_in;
        logic cu_in;
        logic cl_in;
    } port_dir_t;

    function automatic port_dir_t decode_dir(input logic [7:0] w);
        port_dir_t d;
        d.a_in  = w[DIR_A_BIT];
        d.b_in  = w[DIR_B_BIT];
        d.cu_in = w[DIR_CU_BIT];
        d.cl_in = w[DIR_CL_BIT];
        return d;
    endfunction

endpackage

// File: rtl/ppio_bus_fsm.sv
module ppio_bus_fsm
    import ppio_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n,
    input  logic          rd_n,
    input  logic          wr_n,
    input  logic [1:0]    sel,
    input  logic [DW-1:0] din,
    output logic          rd_active,
    output logic          wr_commit,
    output reg_sel_e      wr_sel,
    output logic [DW-1:0] wr_data
);

    bus_state_e state_q, state_d;

    logic chip_on, rd_req, wr_req, clash_req;

    assign chip_on   = !cs_n;
    assign rd_req    = chip_on && !rd_n && wr_n;
    assign wr_req    = chip_on && !wr_n && rd_n;
    assign clash_req = chip_on && !rd_n && !wr_n;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (clash_req)   state_d = ST_CLASH;
                else if (rd_req) state_d = ST_READ;
                else if (wr_req) state_d = ST_WRITE;
            end
            ST_READ: begin
                if (clash_req)   state_d = ST_CLASH;
                else if (!rd_req) state_d = ST_IDLE;
            end
            ST_WRITE:   state_d = ST_WR_HOLD;
            ST_WR_HOLD: begin
                if (!(chip_on && !wr_n)) state_d = ST_IDLE;
            end
            ST_CLASH: begin
                if (!(chip_on && (!rd_n || !wr_n))) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Capture of the write word when the cycle is recognised
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_sel  <= SEL_A;
            wr_data <= '0;
        end else if (state_q == ST_IDLE && wr_req) begin
            wr_sel  <= reg_sel_e'(sel);
            wr_data <= din;
        end
    end

    // State-decoded outputs
    always_comb begin
        rd_active = 1'b0;
        wr_commit = 1'b0;
        unique case (state_q)
            ST_READ:  rd_active = 1'b1;
            ST_WRITE: wr_commit = 1'b1;
            default: ;
        endcase
    end

    // R11: the bus is driven only after a clean selected read was sampled
    p_oe_needs_read_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rd_active |-> $past(rd_req));

    // R2: every recognised write commits for exactly one cycle
    p_commit_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_commit |=> !wr_commit);

    // R9: a conflicting strobe pattern seen in idle never leads to a commit
    p_clash_no_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && clash_req) |=> (!wr_commit && !rd_active));

    // R10: without chip select no cycle starts
    p_idle_without_cs_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && state_q == ST_IDLE) |=> (state_q == ST_IDLE));

endmodule

// File: rtl/ppio_regs.sv
module ppio_regs
    import ppio_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_commit,
    input  reg_sel_e      wr_sel,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] ctrl_q,
    output logic [DW-1:0] lat_a,
    output logic [DW-1:0] lat_b,
    output logic [DW-1:0] lat_c
);

    localparam int IDXW = $clog2(DW);
    localparam int FLAG = DW - 1;

    logic ctrl_wr, mode_wr, bsr_wr;

    assign ctrl_wr = wr_commit && (wr_sel == SEL_CTRL);
    assign mode_wr = ctrl_wr && wr_data[FLAG];
    assign bsr_wr  = ctrl_wr && !wr_data[FLAG];

    // Control register and the A/B output latches
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= DW'(CTRL_RESET);
            lat_a  <= '0;
            lat_b  <= '0;
        end else if (mode_wr) begin
            ctrl_q <= wr_data;
            lat_a  <= '0;
            lat_b  <= '0;
        end else if (wr_commit && wr_sel == SEL_A) begin
            lat_a  <= wr_data;
        end else if (wr_commit && wr_sel == SEL_B) begin
            lat_b  <= wr_data;
        end
    end

    // Port C latch: one flop per bit, each with its own set/reset decode
    for (genvar i = 0; i < DW; i++) begin : g_pc_bit
        logic whole_wr, bit_hit, q;
        assign whole_wr = wr_commit && (wr_sel == SEL_C);
        assign bit_hit  = bsr_wr && (wr_data[IDXW:1] == IDXW'(i));
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        q <= 1'b0;
            else if (mode_wr)  q <= 1'b0;
            else if (whole_wr) q <= wr_data[i];
            else if (bit_hit)  q <= wr_data[0];
        end
        assign lat_c[i] = q;
    end

    // R6: a direction word leaves every latch at zero
    p_mode_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mode_wr |=> (lat_a == '0 && lat_b == '0 && lat_c == '0));

    // R7: a single-bit command changes at most one Port C bit
    p_bsr_one_bit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        bsr_wr |=> ($countones(lat_c ^ $past(lat_c)) <= 1));

    // R7: a single-bit command leaves the stored direction word alone
    p_bsr_keeps_ctrl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        bsr_wr |=> $stable(ctrl_q));

endmodule

// File: rtl/ppio_rd_mux.sv
module ppio_rd_mux
    import ppio_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic [1:0]    sel,
    input  port_dir_t     dir,
    input  logic [DW-1:0] ctrl_q,
    input  logic [DW-1:0] lat_a,
    input  logic [DW-1:0] lat_b,
    input  logic [DW-1:0] lat_c,
    input  logic [DW-1:0] pa_in,
    input  logic [DW-1:0] pb_in,
    input  logic [DW-1:0] pc_in,
    output logic [DW-1:0] rd_data
);

    localparam int HW = DW / 2;

    logic [DW-1:0] c_view;

    // Port C view: each half picks pins or latch by its own direction
    for (genvar h = 0; h < 2; h++) begin : g_c_half
        logic half_in;
        assign half_in = (h == 1) ? dir.cu_in : dir.cl_in;
        assign c_view[h*HW +: HW] = half_in ? pc_in[h*HW +: HW]
                                            : lat_c[h*HW +: HW];
    end

    always_comb begin
        rd_data = '0;
        unique case (reg_sel_e'(sel))
            SEL_A:    rd_data = dir.a_in ? pa_in : lat_a;
            SEL_B:    rd_data = dir.b_in ? pb_in : lat_b;
            SEL_C:    rd_data = c_view;
            SEL_CTRL: rd_data = ctrl_q;
            default:  rd_data = '0;
        endcase
    end

endmodule

// File: rtl/ppio_ctrl.sv
module ppio_ctrl
    import ppio_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n,
    input  logic          rd_n,
    input  logic          wr_n,
    input  logic [1:0]    reg_sel,
    input  logic [DW-1:0] bus_din,
    output logic [DW-1:0] bus_dout,
    output logic          bus_oe,
    input  logic [DW-1:0] pa_in,
    output logic [DW-1:0] pa_out,
    output logic [DW-1:0] pa_oe,
    input  logic [DW-1:0] pb_in,
    output logic [DW-1:0] pb_out,
    output logic [DW-1:0] pb_oe,
    input  logic [DW-1:0] pc_in,
    output logic [DW-1:0] pc_out,
    output logic [DW-1:0] pc_oe
);

    localparam int HW = DW / 2;

    logic          rd_active, wr_commit;
    reg_sel_e      wr_sel;
    logic [DW-1:0] wr_data, ctrl_q, lat_a, lat_b, lat_c, rd_data;
    port_dir_t     dir;

    ppio_bus_fsm #(.DW(DW)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .rd_n      (rd_n),
        .wr_n      (wr_n),
        .sel       (reg_sel),
        .din       (bus_din),
        .rd_active (rd_active),
        .wr_commit (wr_commit),
        .wr_sel    (wr_sel),
        .wr_data   (wr_data)
    );

    ppio_regs #(.DW(DW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_commit (wr_commit),
        .wr_sel    (wr_sel),
        .wr_data   (wr_data),
        .ctrl_q    (ctrl_q),
        .lat_a     (lat_a),
        .lat_b     (lat_b),
        .lat_c     (lat_c)
    );

    assign dir = decode_dir(ctrl_q[7:0]);

    ppio_rd_mux #(.DW(DW)) u_mux (
        .sel     (reg_sel),
        .dir     (dir),
        .ctrl_q  (ctrl_q),
        .lat_a   (lat_a),
        .lat_b   (lat_b),
        .lat_c   (lat_c),
        .pa_in   (pa_in),
        .pb_in   (pb_in),
        .pc_in   (pc_in),
        .rd_data (rd_data)
    );

    assign bus_oe   = rd_active;
    assign bus_dout = rd_active ? rd_data : '0;

    assign pa_out = lat_a;
    assign pb_out = lat_b;
    assign pc_out = lat_c;

    assign pa_oe = {DW{!dir.a_in}};
    assign pb_oe = {DW{!dir.b_in}};
    for (genvar h = 0; h < 2; h++) begin : g_c_oe
        logic half_in;
        assign half_in = (h == 1) ? dir.cu_in : dir.cl_in;
        assign pc_oe[h*HW +: HW] = {HW{!half_in}};
    end

    // R11: nothing is driven onto the bus while idle
    p_quiet_bus_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_oe |-> (bus_dout == '0));

endmodule

// File: tb/ppio_ctrl_test.sv
module ppio_ctrl_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
    logic [1:0] reg_sel = 2'd0;
    logic [7:0] bus_din = 8'h00;
    logic [7:0] bus_dout;
    logic       bus_oe;
    logic [7:0] pa_in = 8'h00, pb_in = 8'h00, pc_in = 8'h00;
    logic [7:0] pa_out, pa_oe, pb_out, pb_oe, pc_out, pc_oe;

    int checks = 0;
    int errors = 0;
    logic done = 1'b0;

    // Bench model
    logic [7:0] m_ctrl = 8'h9B, m_a = 8'h00, m_b = 8'h00, m_c = 8'h00;

    always #5 clk = ~clk;

    ppio_ctrl uut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
        .reg_sel(reg_sel), .bus_din(bus_din), .bus_dout(bus_dout),
        .bus_oe(bus_oe),
        .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
        .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
        .pc_in(pc_in), .pc_out(pc_out), .pc_oe(pc_oe)
    );

    task automatic check(input string tag, input logic [7:0] act,
                         input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_read(input logic [1:0] s);
        case (s)
            2'd0:    return m_ctrl[4] ? pa_in : m_a;
            2'd1:    return m_ctrl[1] ? pb_in : m_b;
            2'd2:    return {m_ctrl[3] ? pc_in[7:4] : m_c[7:4],
                             m_ctrl[0] ? pc_in[3:0] : m_c[3:0]};
            default: return m_ctrl;
        endcase
    endfunction

    function automatic logic [7:0] exp_oe(input logic [1:0] s);
        case (s)
            2'd0:    return m_ctrl[4] ? 8'h00 : 8'hFF;
            2'd1:    return m_ctrl[1] ? 8'h00 : 8'hFF;
            default: return {m_ctrl[3] ? 4'h0 : 4'hF, m_ctrl[0] ? 4'h0 : 4'hF};
        endcase
    endfunction

    task automatic model_write(input logic [1:0] s, input logic [7:0] d);
        case (s)
            2'd0: m_a = d;
            2'd1: m_b = d;
            2'd2: m_c = d;
            default: begin
                if (d[7]) begin
                    m_ctrl = d; m_a = 0; m_b = 0; m_c = 0;
                end else begin
                    m_c[d[3:1]] = d[0];
                end
            end
        endcase
    endtask

    task automatic check_pins(input string tag);
        check({tag, " pa_out"}, pa_out, m_a);
        check({tag, " pb_out"}, pb_out, m_b);
        check({tag, " pc_out"}, pc_out, m_c);
        check({tag, " pa_oe"}, pa_oe, exp_oe(2'd0));
        check({tag, " pb_oe"}, pb_oe, exp_oe(2'd1));
        check({tag, " pc_oe"}, pc_oe, exp_oe(2'd2));
    endtask

    task automatic bus_write(input logic [1:0] s, input logic [7:0] d);
        @(negedge clk);
        reg_sel = s; bus_din = d; cs_n = 0; wr_n = 0;
        repeat (3) @(negedge clk);
        check("R11 no drive during write", {7'd0, bus_oe}, 8'h00);
        cs_n = 1; wr_n = 1;
        @(negedge clk);
        model_write(s, d);
    endtask

    task automatic bus_read(input logic [1:0] s, output logic [7:0] v);
        @(negedge clk);
        reg_sel = s; cs_n = 0; rd_n = 0;
        repeat (2) @(negedge clk);
        check("R11 drive during read", {7'd0, bus_oe}, 8'h01);
        v = bus_dout;
        cs_n = 1; rd_n = 1;
        @(negedge clk);
        check("R11 released after read", {7'd0, bus_oe}, 8'h00);
    endtask

    task automatic read_check(input string tag, input logic [1:0] s);
        logic [7:0] v;
        bus_read(s, v);
        check(tag, v, exp_read(s));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        int unsigned seed;
        seed = $urandom(32'h5EED_1234);

        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1: reset state
        check_pins("R1 reset");
        check("R1 bus idle", bus_dout, 8'h00);
        read_check("R1 ctrl reset value", 2'd3);

        // R5 / R6: direction words
        bus_write(2'd3, 8'h8B);
        check_pins("R5 8Bh");
        read_check("R6 ctrl readback 8Bh", 2'd3);

        // R2 / R4: output port write and readback
        bus_write(2'd0, 8'h5A);
        check_pins("R2 write A");
        read_check("R4 read A latch", 2'd0);

        bus_write(2'd3, 8'h89);
        check_pins("R6 89h clears latches");
        bus_write(2'd1, 8'h3C);
        check_pins("R2 write B");
        bus_write(2'd2, 8'hA5);
        check_pins("R2 write C");
        bus_write(2'd3, 8'h80);
        check_pins("R6 80h clears C");

        // R7: single-bit commands
        bus_write(2'd3, 8'h05);
        check("R7 set PC2", pc_out, 8'h04);
        bus_write(2'd3, 8'h0D);
        check("R7 set PC6", pc_out, 8'h44);
        bus_write(2'd3, 8'h0C);
        check("R7 clear PC6", pc_out, 8'h04);
        read_check("R7 ctrl unchanged", 2'd3);

        // R8: independent Port C halves
        bus_write(2'd3, 8'h88);
        bus_write(2'd2, 8'h5A);
        pc_in = 8'hC3;
        check("R8 pc_oe upper in", pc_oe, 8'h0F);
        bus_read(2'd2, v);
        check("R8 merge upper pins", v, 8'hCA);
        bus_write(2'd3, 8'h81);
        bus_write(2'd2, 8'h5A);
        check("R8 pc_oe lower in", pc_oe, 8'hF0);
        bus_read(2'd2, v);
        check("R8 merge lower pins", v, 8'h53);

        // R3: live input while a read is held
        bus_write(2'd3, 8'h9B);
        pa_in = 8'h11;
        @(negedge clk);
        reg_sel = 2'd0; cs_n = 0; rd_n = 0;
        repeat (2) @(negedge clk);
        check("R3 live read first", bus_dout, 8'h11);
        pa_in = 8'hEE;
        @(negedge clk);
        check("R3 live read follows pins", bus_dout, 8'hEE);
        cs_n = 1; rd_n = 1;
        @(negedge clk);

        // R9: read and write together
        bus_write(2'd3, 8'h80);
        bus_write(2'd0, 8'h77);
        @(negedge clk);
        reg_sel = 2'd0; bus_din = 8'h00; cs_n = 0; rd_n = 0; wr_n = 0;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            check("R9 no drive in clash", {7'd0, bus_oe}, 8'h00);
        end
        cs_n = 1; rd_n = 1; wr_n = 1;
        @(negedge clk);
        check("R9 latch kept after clash", pa_out, 8'h77);
        // write joining a running read
        reg_sel = 2'd0; cs_n = 0; rd_n = 0;
        @(negedge clk);
        @(negedge clk);
        wr_n = 0;
        repeat (3) @(negedge clk);
        check("R9 drive dropped on clash", {7'd0, bus_oe}, 8'h00);
        cs_n = 1; rd_n = 1; wr_n = 1;
        @(negedge clk);
        read_check("R9 A unchanged", 2'd0);

        // R10: strobes without chip select
        @(negedge clk);
        reg_sel = 2'd0; bus_din = 8'h00; wr_n = 0;
        repeat (4) @(negedge clk);
        wr_n = 1; rd_n = 0;
        repeat (3) @(negedge clk);
        check("R10 no drive without cs", {7'd0, bus_oe}, 8'h00);
        rd_n = 1;
        @(negedge clk);
        check("R10 latch kept", pa_out, 8'h77);

        // Constrained random mix
        for (int n = 0; n < 300; n++) begin
            int op;
            logic [1:0] s;
            logic [7:0] d;
            pa_in = 8'($urandom); pb_in = 8'($urandom); pc_in = 8'($urandom);
            op = int'($urandom_range(0, 7));
            s  = 2'($urandom_range(0, 2));
            d  = 8'($urandom);
            case (op)
                0, 1, 2: begin
                    bus_write(s, d);
                    check_pins("R2 random write");
                end
                3: begin
                    bus_write(2'd3, d | 8'h80);
                    check_pins("R5 R6 random direction word");
                end
                4: begin
                    bus_write(2'd3, d & 8'h0F);
                    check_pins("R7 random bit command");
                end
                default: begin
                    s = 2'($urandom_range(0, 3));
                    read_check("R3 R4 R8 random read", s);
                end
            endcase
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule